// File: doc/BRIEF.md
# Key-Sequence Watchdog Timer

This block is a watchdog timer with a small register write port. Software proves it is alive by writing a two-step key to a key register: first the arm value 0x55, then the service value 0xAA. A valid service clears an 8-bit up-counter. The counter advances on each cycle in which the prescale enable `tick_i` is high. If software stops servicing, the counter wraps past its all-ones value and the block raises an alarm.

Bits in a control register select how the alarm is reported. It is either a reset request pulse of fixed length, or an interrupt level that stays high until the next valid service. A disable bit in the same register stops the counter. Every control write must carry the check pattern 101 in its low three bits. A write with any other pattern updates nothing and raises the alarm at once. Key values other than the two defined ones are silently ignored.

Register map: address 0 is the key register, taking an 8-bit key. Address 1 is the control register, with fields `chk` in bits [2:0] (must be 101), `irq_mode` in bit 3 (0 = reset pulse, 1 = interrupt level) and `halt` in bit 4 (1 = counter stopped). Bits [7:5] are ignored.

Top module: `keyseq_wdog`

## Requirements
- R1: After reset `rst_req_o` and `irq_o` are low, the counter is zero, the alarm mode is reset-pulse (`irq_mode`=0), counting is enabled (`halt`=0) and the key sequence is not armed.
- R2: A key write of 0x55 arms the sequence. A following key write of 0xAA clears the counter and disarms the sequence, so a second 0xAA does nothing.
- R3: A key write of 0xAA while the sequence is not armed has no effect: the counter is not cleared and a pending interrupt stays high.
- R4: A key write of any value other than 0x55 or 0xAA has no effect. It neither disarms the sequence nor raises an alarm.
- R5: Repeated key writes of 0x55 keep the sequence armed, so a later 0xAA still services the watchdog.
- R6: With `halt`=0 the counter advances by one on each cycle with `tick_i` high. The 256th tick after a clear raises the alarm, visible on the outputs in the following cycle, and the counter wraps to zero.
- R7: In reset-pulse mode an alarm drives `rst_req_o` high for exactly 512 consecutive cycles, starting in the cycle after the alarm event. A new alarm during the pulse restarts the 512-cycle count.
- R8: In interrupt mode an alarm sets `irq_o` in the following cycle. `irq_o` stays high until a valid 0x55/0xAA service and falls in the cycle after the 0xAA write.
- R9: A control write whose bits [2:0] are not 101 raises the alarm in the currently selected mode in the following cycle, and it leaves `irq_mode` and `halt` unchanged.
- R10: With `halt`=1 the counter holds, so no timeout occurs however many ticks arrive. `halt` and `irq_mode` change only on a control write carrying check pattern 101.
- R11: When a valid 0xAA service lands in the same cycle as the tick that would overflow the counter, the service wins: no alarm is raised, and the counter restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaled count enable, one cycle per counter step |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W (2) | Register address: 0 key, 1 control |
| wr_data_i | input | 8 | Write data |
| rst_req_o | output | 1 | Reset request pulse |
| irq_o | output | 1 | Interrupt level |

## Verification
A service write and the overflowing tick can fall in the same cycle. The bench provokes this by serving with 0x55, letting exactly 255 ticks pass and then writing 0xAA with `tick_i` high. It judges that no alarm appears in the next cycle and that a full 256 further ticks are needed for the next timeout. A second collision is an alarm event while an interrupt is pending or a reset pulse is running. Constrained-random writes and ticks provoke it, and a cycle model in the bench judges that the set or reload wins over the clear and that the pulse length restarts.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W = 8;
  localparam int CHK_W  = 3;

  localparam logic [DATA_W-1:0] KEY_ARM   = 8'h55;
  localparam logic [DATA_W-1:0] KEY_SERVE = 8'hAA;
  localparam logic [CHK_W-1:0]  CHK_OK    = 3'b101;

  // control word layout, low bits of the write data
  typedef struct packed {
    logic             halt;
    logic             irq_mode;
    logic [CHK_W-1:0] chk;
  } ctrl_word_t;

  localparam int CTRL_W = $bits(ctrl_word_t);
endpackage

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
  import wdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_wr_i,
  input  logic [DATA_W-1:0] key_i,
  output logic              kick_o
);
  logic armed_q;
  logic is_arm, is_serve;

  assign is_arm   = (key_i == KEY_ARM);
  assign is_serve = (key_i == KEY_SERVE);
  assign kick_o   = key_wr_i && is_serve && armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
    end else if (key_wr_i) begin
      if (is_arm)        armed_q <= 1'b1;
      else if (is_serve) armed_q <= 1'b0;
    end
  end

  p_arm_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_wr_i && (key_i == 8'h55) |=> armed_q);
  p_disarm_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_o |=> !armed_q);
  p_unarmed_serve_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_wr_i && (key_i == 8'hAA) && !armed_q |-> !kick_o);
  p_other_key_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_wr_i && (key_i != 8'h55) && (key_i != 8'hAA) |=> armed_q == $past(armed_q));
  p_rearm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && key_wr_i && (key_i == 8'h55) |=> armed_q);
endmodule

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
  import wdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              irq_mode_o,
  output logic              halt_o,
  output logic              bad_chk_o
);
  ctrl_word_t word;
  logic chk_good;

  assign word      = ctrl_word_t'(ctrl_i);
  assign chk_good  = (word.chk == CHK_OK);
  assign bad_chk_o = ctrl_wr_i && !chk_good;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_mode_o <= 1'b0;
      halt_o     <= 1'b0;
    end else if (ctrl_wr_i && chk_good) begin
      irq_mode_o <= word.irq_mode;
      halt_o     <= word.halt;
    end
  end

  p_bad_keeps_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i && (ctrl_i[2:0] != 3'b101) |=> $stable(irq_mode_o) && $stable(halt_o));
  p_good_loads_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i && (ctrl_i[2:0] == 3'b101) |=> halt_o == $past(ctrl_i[4]) && irq_mode_o == $past(ctrl_i[3]));
  p_no_write_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr_i |=> $stable(halt_o) && $stable(irq_mode_o));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic halt_i,
  input  logic kick_i,
  output logic timeout_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic step;

  assign step      = tick_i && !halt_i && !kick_i;
  assign timeout_o = step && (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (kick_i) cnt_q <= '0;
    else if (step)   cnt_q <= cnt_q + 1'b1;  // wraps on timeout
  end

  p_kick_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> cnt_q == '0);
  p_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !halt_i && !kick_i |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  p_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> cnt_q == '0);
  p_halt_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i && !kick_i |=> $stable(cnt_q));
  p_serve_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |-> !timeout_o);
endmodule

// File: rtl/wdog_alarm_out.sv
module wdog_alarm_out #(
  parameter int PULSE_LEN = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic irq_mode_i,
  input  logic kick_i,
  output logic rst_req_o,
  output logic irq_o
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic fire_rst, fire_irq;
  assign fire_rst = fire_i && !irq_mode_i;
  assign fire_irq = fire_i && irq_mode_i;

  generate
    if (PULSE_LEN > 1) begin : g_stretch
      logic [PW-1:0] left_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 left_q <= '0;
        else if (fire_rst)           left_q <= PW'(PULSE_LEN);
        else if (left_q != '0)       left_q <= left_q - 1'b1;
      end
      assign rst_req_o = (left_q != '0);
    end else begin : g_single
      logic pulse_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pulse_q <= 1'b0;
        else         pulse_q <= fire_rst;
      end
      assign rst_req_o = pulse_q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       irq_o <= 1'b0;
    else if (fire_irq) irq_o <= 1'b1;  // set beats clear
    else if (kick_i)   irq_o <= 1'b0;
  end

  p_pulse_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && !irq_mode_i |=> rst_req_o);
  p_no_pulse_in_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_req_o && !(fire_i && !irq_mode_i) |=> !rst_req_o);
  p_irq_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && irq_mode_i |=> irq_o);
  p_irq_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !kick_i |=> irq_o);
  p_irq_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && kick_i && !fire_i |=> !irq_o);
  p_irq_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o && !(fire_i && irq_mode_i) |=> !irq_o);
endmodule

// File: rtl/keyseq_wdog.sv
module keyseq_wdog
  import wdog_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int PULSE_LEN = 512,
  parameter int ADDR_W    = 2,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              rst_req_o,
  output logic              irq_o
);
  logic key_wr, ctrl_wr;
  logic kick, timeout, bad_chk, fire;
  logic irq_mode, halt;

  assign key_wr  = wr_en_i && (wr_addr_i == KEY_ADDR);
  assign ctrl_wr = wr_en_i && (wr_addr_i == CTRL_ADDR);
  assign fire    = timeout || bad_chk;

  wdog_key_seq u_key (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .key_wr_i (key_wr),
    .key_i    (wr_data_i),
    .kick_o   (kick)
  );

  wdog_ctrl_reg u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_wr_i  (ctrl_wr),
    .ctrl_i     (wr_data_i[CTRL_W-1:0]),
    .irq_mode_o (irq_mode),
    .halt_o     (halt),
    .bad_chk_o  (bad_chk)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .halt_i    (halt),
    .kick_i    (kick),
    .timeout_o (timeout)
  );

  wdog_alarm_out #(.PULSE_LEN(PULSE_LEN)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (fire),
    .irq_mode_i (irq_mode),
    .kick_i     (kick),
    .rst_req_o  (rst_req_o),
    .irq_o      (irq_o)
  );

  p_bad_chk_fires_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && (wr_data_i[2:0] != 3'b101) |=> rst_req_o || irq_o);
  p_outputs_exclusive_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_mode && !irq_o && !fire |=> !irq_o);
endmodule

// File: tb/keyseq_wdog_tb.sv
`timescale 1ns/1ps
module keyseq_wdog_tb;
  localparam int PULSE = 512;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] data = 8'd0;
  logic       rst_req, irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model state
  bit     m_armed, m_mode, m_halt, m_irq;
  int     m_cnt, m_pulse;

  always #10 clk = ~clk;

  keyseq_wdog u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(we),
    .wr_addr_i(addr), .wr_data_i(data), .rst_req_o(rst_req), .irq_o(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model_step(input bit w, input bit [1:0] a, input bit [7:0] d, input bit tk);
    bit kick, bad, tmo;
    kick = w && a == 2'd0 && d == 8'hAA && m_armed;
    bad  = w && a == 2'd1 && d[2:0] != 3'b101;
    tmo  = !kick && tk && !m_halt && m_cnt == 255;
    // outputs use the mode in force before this cycle's write
    if ((tmo || bad) && !m_mode) m_pulse = PULSE;
    else if (m_pulse > 0) m_pulse--;
    if ((tmo || bad) && m_mode) m_irq = 1'b1;
    else if (kick) m_irq = 1'b0;
    if (kick) m_cnt = 0;
    else if (tk && !m_halt) m_cnt = (m_cnt + 1) % 256;
    if (w && a == 2'd0) begin
      if (d == 8'h55) m_armed = 1'b1;
      else if (d == 8'hAA) m_armed = 1'b0;
    end
    if (w && a == 2'd1 && d[2:0] == 3'b101) begin
      m_mode = d[3];
      m_halt = d[4];
    end
  endfunction

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input bit w, input bit [1:0] a, input bit [7:0] d, input bit tk);
    we = w; addr = a; data = d; tick = tk;
    @(posedge clk);
    model_step(w, a, d, tk);
    @(negedge clk);
    we = 1'b0; tick = 1'b0;
    check("R7 rst_req_o model", int'(rst_req), int'(m_pulse > 0));
    check("R8 irq_o model", int'(irq), int'(m_irq));
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 8'h00, 1'b1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 8'h00, 1'b0);
  endtask

  task automatic key(input bit [7:0] k);
    cyc(1'b1, 2'd0, k, 1'b0);
  endtask

  task automatic ctrl(input bit [7:0] c);
    cyc(1'b1, 2'd1, c, 1'b0);
  endtask

  task automatic serve();
    key(8'h55);
    key(8'hAA);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int plen;
    int seed;
    seed = $urandom(32'd4242);
    m_armed = 0; m_mode = 0; m_halt = 0; m_irq = 0; m_cnt = 0; m_pulse = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    check("R1 rst_req_o after reset", int'(rst_req), 0);
    check("R1 irq_o after reset", int'(irq), 0);

    // R6/R7: timeout in default reset-pulse mode
    ticks(255);
    check("R6 no alarm after 255 ticks", int'(rst_req), 0);
    ticks(1);
    check("R6 alarm on 256th tick", int'(rst_req), 1);
    plen = 1;
    while (rst_req && plen < 2000) begin
      idle(1);
      if (rst_req) plen++;
    end
    check("R7 pulse length", plen, PULSE);

    // R2/R4/R5: bad keys ignored, repeated arm kept
    ticks(200);
    key(8'h55);
    key(8'h55);
    key(8'h12);
    key(8'hAA);
    ticks(255);
    check("R2 R4 R5 service after 55,55,12,AA cleared counter", int'(rst_req), 0);
    key(8'hAA);  // second AA, sequence disarmed
    ticks(1);
    check("R2 second AA did not clear", int'(rst_req), 1);
    idle(PULSE);

    // R8/R3/R4: interrupt mode
    ctrl(8'h0D);
    serve();
    ticks(256);
    check("R8 irq set on timeout", int'(irq), 1);
    check("R8 no reset pulse in irq mode", int'(rst_req), 0);
    key(8'hAA);
    check("R3 unarmed AA leaves irq", int'(irq), 1);
    key(8'h3C);
    check("R4 other key leaves irq", int'(irq), 1);
    key(8'h55);
    key(8'h99);
    check("R4 other key after arm leaves irq", int'(irq), 1);
    key(8'hAA);
    check("R8 R4 irq cleared, arm survived bad key", int'(irq), 0);

    // R9: bad check pattern fires in current mode, mode unchanged
    ctrl(8'h06);
    check("R9 bad check raises irq", int'(irq), 1);
    serve();
    ctrl(8'h00);
    check("R9 mode kept after bad write", int'(irq), 1);
    check("R9 no pulse while mode kept irq", int'(rst_req), 0);
    serve();

    // R10: halt stops counting; bad write cannot release it
    ctrl(8'h15);
    ticks(600);
    check("R10 halted no pulse", int'(rst_req), 0);
    ctrl(8'h00);
    check("R9 bad check in reset mode pulses", int'(rst_req), 1);
    idle(PULSE);
    ticks(600);
    check("R10 still halted after bad write", int'(rst_req), 0);
    ctrl(8'h05);
    serve();

    // R11: service collides with overflowing tick
    ticks(255);
    key(8'h55);
    cyc(1'b1, 2'd0, 8'hAA, 1'b1);
    check("R11 service wins over overflow", int'(rst_req), 0);
    ticks(255);
    check("R11 counter restarted at zero", int'(rst_req), 0);
    ticks(1);
    check("R11 R6 next timeout after 256 ticks", int'(rst_req), 1);

    // constrained random
    for (int i = 0; i < 30000; i++) begin
      bit w, tk;
      bit [1:0] a;
      bit [7:0] d;
      w  = ($urandom % 8) == 0;
      tk = ($urandom % 4) != 0;
      a  = 2'(($urandom % 5) == 0 ? 1 : 0);
      if (a == 2'd0) begin
        case ($urandom % 4)
          0, 3: d = 8'h55;
          1:    d = 8'hAA;
          default: d = 8'($urandom);
        endcase
      end else begin
        d = 8'($urandom);
        if (($urandom % 8) != 0) d[2:0] = 3'b101;
        if (($urandom % 4) != 0) d[4] = 1'b0;
      end
      cyc(w, a, d, tk);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule